// File: doc/BRIEF.md
# Data Address Translation Checker

This block makes the data-side translation decision for one memory access per request. The load/store pipe supplies the virtual address, the access size and the request qualifiers. The block also receives the result of a separate TLB lookup: the hit flag, the physical page number, the per-mode read and write enable masks, and the fault-on-read and fault-on-write bits. One clock later the block returns the physical address, an uncacheable flag, a fault code, and a vector of status flags that describes the fault.

The checks run in a fixed priority order:

1. Misalignment.
2. Physical bypass or virtual-address validity.
3. The kernel-only superpage window, whose mapping is fixed.
4. TLB miss.
5. Per-mode permission and fault-on bits.
6. The implemented physical-address width.
7. The uncacheable-space decode.

The first check that fails sets the fault code and the status flags. When the program counter's low bit marks privileged code, the mode used for the permission check is replaced: it becomes the alternate mode if the request asks for it, and kernel mode otherwise.

Encodings used throughout:

| Item | Encoding |
|---|---|
| Mode (`cur_mode`, `alt_mode`) | 0 kernel, 1 executive, 2 supervisor, 3 user |
| Enable masks | bit m enables mode m |
| Fault code | 0 none, 1 alignment, 2 page, 3 access violation, 4 normal miss, 5 table-fetch miss, 6 machine check, 7 unimplemented |
| Status flag bits | [0] write, [1] access violation, [2] fault-on-read, [3] fault-on-write, [4] bad VA, [5] miss |

Top module: `dtc_translate_chk`

## Requirements
- R1: If `req_va & (req_size-1)` is nonzero, the fault is 1 (alignment), whatever the other inputs are. The status holds only bit 0, which is set for writes.
- R2: The effective mode is `cur_mode` when `pc_lsb` is 0. When `pc_lsb` is 1 it is `alt_mode` if `req_alt` is 1, and kernel (0) otherwise. R8 and R9 use this effective mode.
- R3: With `req_phys` set, the physical address equals the virtual address. VA validity, the superpage window, TLB and permission checks are all skipped. R10 and R11 still apply.
- R4: A virtual address whose bits 63:42 are neither all zero nor all one gives fault 2. The status is 0x12, with bit 0 added for writes.
- R5: VA[47:41] = 0x7e selects the superpage window, and no TLB lookup is made. It is legal only when `cur_mode` (not the effective mode) is kernel; otherwise the fault is 3 with status 0x02, plus bit 0 for writes. The physical address is VA[43:0]. If bit 40 is set, bits 43:40 are forced to one; otherwise bits 63:40 are cleared.
- R6: A TLB miss gives fault 5 if `req_ptefetch` is set and fault 4 otherwise. The status is 0x20, plus bit 0 for writes.
- R7: On a hit the physical address is `(tlb_ppn << 13) + VA[12:0]`.
- R8: A write whose `tlb_wr_en` lacks the effective-mode bit gives fault 2 with status 0x03, plus 0x08 if `tlb_fow` is set. Otherwise, if `tlb_fow` is set, the write gives fault 2 with status 0x09.
- R9: A read whose `tlb_rd_en` lacks the effective-mode bit gives fault 3 with status 0x02, plus 0x04 if `tlb_for` is set. Otherwise, if `tlb_for` is set, the read gives fault 2 with status 0x04.
- R10: A physical address with any bit above 43 set gives fault 6 with status 0.
- R11: A physical address with bit 43 set is handled in one of two ways. If bits 43:20 are all one (internal-register space), the fault is 7 with status 0. Otherwise the access has no fault, `rsp_uncached` is 1, and physical bits 42:35 are cleared.
- R12: Whenever the fault is nonzero, `rsp_pa` is 0 and `rsp_uncached` is 0. Without a fault the status is 0.
- R13: The outputs are registered, with one cycle of latency. `rsp_valid` follows `req_valid`. After reset, and in a cycle after no request, all outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present this cycle |
| req_va | input | 64 | Virtual address |
| req_size | input | 4 | Access size in bytes (1, 2, 4, 8) |
| req_write | input | 1 | 1 for a store |
| req_phys | input | 1 | Physical bypass |
| req_alt | input | 1 | Use the alternate mode under privileged code |
| req_ptefetch | input | 1 | Request is a page-table-entry fetch |
| pc_lsb | input | 1 | Program counter bit 0 (privileged code) |
| cur_mode | input | 2 | Current mode |
| alt_mode | input | 2 | Alternate mode |
| tlb_hit | input | 1 | TLB lookup matched |
| tlb_ppn | input | PPN_W | Physical page number of the matching entry |
| tlb_rd_en | input | 4 | Read enable, one bit per mode |
| tlb_wr_en | input | 4 | Write enable, one bit per mode |
| tlb_for | input | 1 | Fault on read |
| tlb_fow | input | 1 | Fault on write |
| rsp_valid | output | 1 | Result valid |
| rsp_pa | output | 64 | Physical address (0 on fault) |
| rsp_uncached | output | 1 | Access is uncacheable |
| rsp_fault | output | 3 | Fault code |
| rsp_stat | output | 6 | Status flags |

## Verification
The bench uses the defaults, PPN_W = 32 and PAGE_SHIFT = 13. A hit can therefore produce a 45-bit physical address, so the machine-check path is reachable from ordinary TLB data and not only from the bypass. The physical page number also reaches bit 43. This lets random hits exercise the uncacheable clearing of bits 42:35. Directed cases set page-number bits 30:7 to reach the internal-register decode through a hit, and VA bits 40:20 to reach it through the superpage window.

// File: rtl/dtc_pkg.sv
package dtc_pkg;

    localparam int ADDR_W      = 64;
    localparam int VA_VALID_W  = 43;
    localparam int PA_IMPL_W   = 44;
    localparam int SP_HI       = 47;
    localparam int SP_LO       = 41;
    localparam logic [SP_HI-SP_LO:0] SP_TAG = 7'h7e;
    localparam int SP_SEXT_BIT = 40;
    localparam int UC_BIT      = 43;
    localparam int UC_CLR_HI   = 42;
    localparam int UC_CLR_LO   = 35;
    localparam int IRS_LO      = 20;
    localparam int NUM_MODES   = 4;

    localparam int ST_W     = 6;
    localparam int ST_WR    = 0;
    localparam int ST_ACV   = 1;
    localparam int ST_FOR   = 2;
    localparam int ST_FOW   = 3;
    localparam int ST_BADVA = 4;
    localparam int ST_MISS  = 5;

    typedef enum logic [2:0] {
        FLT_NONE     = 3'd0,
        FLT_ALIGN    = 3'd1,
        FLT_PAGE     = 3'd2,
        FLT_ACV      = 3'd3,
        FLT_MISS_NAT = 3'd4,
        FLT_MISS_PTE = 3'd5,
        FLT_MCHK     = 3'd6,
        FLT_UNIMP    = 3'd7
    } fault_e;

    typedef enum logic [1:0] {
        MODE_KERNEL = 2'd0,
        MODE_EXEC   = 2'd1,
        MODE_SUPER  = 2'd2,
        MODE_USER   = 2'd3
    } mode_e;

    typedef struct packed {
        fault_e          code;
        logic [ST_W-1:0] stat;
    } verdict_t;

    localparam logic [ADDR_W-1:0] IMPL_MASK = (ADDR_W'(1) << PA_IMPL_W) - ADDR_W'(1);
    localparam logic [ADDR_W-1:0] LOW_MASK  = (ADDR_W'(1) << SP_SEXT_BIT) - ADDR_W'(1);
    localparam logic [ADDR_W-1:0] SEXT_OR   = IMPL_MASK & ~LOW_MASK;

    function automatic logic misaligned(input logic [ADDR_W-1:0] va, input logic [3:0] size);
        return |(va[3:0] & (size - 4'd1));
    endfunction

    function automatic logic va_canonical(input logic [ADDR_W-1:0] va);
        return (&va[ADDR_W-1:VA_VALID_W-1]) || !(|va[ADDR_W-1:VA_VALID_W-1]);
    endfunction

    function automatic logic in_superpage(input logic [ADDR_W-1:0] va);
        return va[SP_HI:SP_LO] == SP_TAG;
    endfunction

    function automatic logic [ADDR_W-1:0] superpage_pa(input logic [ADDR_W-1:0] va);
        logic [ADDR_W-1:0] p;
        p = va & IMPL_MASK;
        if (p[SP_SEXT_BIT]) p = p | SEXT_OR;
        else                p = p & LOW_MASK;
        return p;
    endfunction

    function automatic logic irs_space(input logic [ADDR_W-1:0] pa);
        return &pa[UC_BIT:IRS_LO];
    endfunction

    function automatic logic [ADDR_W-1:0] strip_uc(input logic [ADDR_W-1:0] pa);
        logic [ADDR_W-1:0] p;
        p = pa;
        p[UC_CLR_HI:UC_CLR_LO] = '0;
        return p;
    endfunction

endpackage

// File: rtl/dtc_mode_sel.sv
module dtc_mode_sel
    import dtc_pkg::*;
(
    input  logic  pc_lsb,
    input  logic  use_alt,
    input  mode_e cur_mode,
    input  mode_e alt_mode,
    output mode_e eff_mode
);

    always_comb begin
        if (!pc_lsb)      eff_mode = cur_mode;
        else if (use_alt) eff_mode = alt_mode;
        else              eff_mode = MODE_KERNEL;
    end

endmodule

// File: rtl/dtc_va_map.sv
module dtc_va_map
    import dtc_pkg::*;
#(
    parameter int PPN_W      = 32,
    parameter int PAGE_SHIFT = 13
) (
    input  logic [ADDR_W-1:0]    va,
    input  logic [3:0]           size,
    input  logic                 write,
    input  logic                 phys,
    input  logic                 ptefetch,
    input  mode_e                cur_mode,
    input  mode_e                eff_mode,
    input  logic                 hit,
    input  logic [PPN_W-1:0]     ppn,
    input  logic [NUM_MODES-1:0] rd_en,
    input  logic [NUM_MODES-1:0] wr_en,
    input  logic                 f_on_rd,
    input  logic                 f_on_wr,
    output verdict_t             early,
    output logic [ADDR_W-1:0]    pa_raw
);

    localparam logic [ST_W-1:0] WR_FLAG = ST_W'(1) << ST_WR;

    logic [ST_W-1:0]      wr_bit;
    logic [NUM_MODES-1:0] mode_bit;
    logic [ADDR_W-1:0]    hit_pa;

    assign wr_bit   = write ? WR_FLAG : '0;
    assign mode_bit = NUM_MODES'(1) << eff_mode;
    assign hit_pa   = (ADDR_W'(ppn) << PAGE_SHIFT) + ADDR_W'(va[PAGE_SHIFT-1:0]);

    always_comb begin
        early.code = FLT_NONE;
        early.stat = '0;
        pa_raw     = '0;
        if (misaligned(va, size)) begin
            early.code = FLT_ALIGN;
            early.stat = wr_bit;
        end else if (phys) begin
            pa_raw = va;
        end else if (!va_canonical(va)) begin
            early.code = FLT_PAGE;
            early.stat = wr_bit | (ST_W'(1) << ST_BADVA) | (ST_W'(1) << ST_ACV);
        end else if (in_superpage(va)) begin
            if (cur_mode != MODE_KERNEL) begin
                early.code = FLT_ACV;
                early.stat = wr_bit | (ST_W'(1) << ST_ACV);
            end else begin
                pa_raw = superpage_pa(va);
            end
        end else if (!hit) begin
            early.code = ptefetch ? FLT_MISS_PTE : FLT_MISS_NAT;
            early.stat = wr_bit | (ST_W'(1) << ST_MISS);
        end else begin
            pa_raw = hit_pa;
            if (write) begin
                if (!(|(wr_en & mode_bit))) begin
                    early.code = FLT_PAGE;
                    early.stat = WR_FLAG | (ST_W'(1) << ST_ACV)
                               | (f_on_wr ? (ST_W'(1) << ST_FOW) : '0);
                end else if (f_on_wr) begin
                    early.code = FLT_PAGE;
                    early.stat = WR_FLAG | (ST_W'(1) << ST_FOW);
                end
            end else begin
                if (!(|(rd_en & mode_bit))) begin
                    early.code = FLT_ACV;
                    early.stat = (ST_W'(1) << ST_ACV)
                               | (f_on_rd ? (ST_W'(1) << ST_FOR) : '0);
                end else if (f_on_rd) begin
                    early.code = FLT_PAGE;
                    early.stat = ST_W'(1) << ST_FOR;
                end
            end
        end
    end

endmodule

// File: rtl/dtc_pa_check.sv
module dtc_pa_check
    import dtc_pkg::*;
(
    input  verdict_t          early,
    input  logic [ADDR_W-1:0] pa_raw,
    output verdict_t          final_v,
    output logic [ADDR_W-1:0] pa_out,
    output logic              uncached
);

    always_comb begin
        final_v  = early;
        pa_out   = '0;
        uncached = 1'b0;
        if (early.code == FLT_NONE) begin
            if (|(pa_raw & ~IMPL_MASK)) begin
                final_v.code = FLT_MCHK;
                final_v.stat = '0;
            end else if (pa_raw[UC_BIT]) begin
                if (irs_space(pa_raw)) begin
                    final_v.code = FLT_UNIMP;
                    final_v.stat = '0;
                end else begin
                    uncached = 1'b1;
                    pa_out   = strip_uc(pa_raw);
                end
            end else begin
                pa_out = pa_raw;
            end
        end
    end

endmodule

// File: rtl/dtc_translate_chk.sv
module dtc_translate_chk
    import dtc_pkg::*;
#(
    parameter int PPN_W      = 32,
    parameter int PAGE_SHIFT = 13
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 req_valid,
    input  logic [ADDR_W-1:0]    req_va,
    input  logic [3:0]           req_size,
    input  logic                 req_write,
    input  logic                 req_phys,
    input  logic                 req_alt,
    input  logic                 req_ptefetch,
    input  logic                 pc_lsb,
    input  logic [1:0]           cur_mode,
    input  logic [1:0]           alt_mode,
    input  logic                 tlb_hit,
    input  logic [PPN_W-1:0]     tlb_ppn,
    input  logic [NUM_MODES-1:0] tlb_rd_en,
    input  logic [NUM_MODES-1:0] tlb_wr_en,
    input  logic                 tlb_for,
    input  logic                 tlb_fow,
    output logic                 rsp_valid,
    output logic [ADDR_W-1:0]    rsp_pa,
    output logic                 rsp_uncached,
    output logic [2:0]           rsp_fault,
    output logic [ST_W-1:0]      rsp_stat
);

    mode_e             eff_mode;
    verdict_t          early_v, final_v, verdict_q;
    logic [ADDR_W-1:0] pa_raw, pa_chk;
    logic              uc_chk;

    initial begin
        if (PPN_W + PAGE_SHIFT > ADDR_W) $error("page number does not fit the address");
    end

    dtc_mode_sel u_mode (
        .pc_lsb   (pc_lsb),
        .use_alt  (req_alt),
        .cur_mode (mode_e'(cur_mode)),
        .alt_mode (mode_e'(alt_mode)),
        .eff_mode (eff_mode)
    );

    dtc_va_map #(.PPN_W(PPN_W), .PAGE_SHIFT(PAGE_SHIFT)) u_map (
        .va       (req_va),
        .size     (req_size),
        .write    (req_write),
        .phys     (req_phys),
        .ptefetch (req_ptefetch),
        .cur_mode (mode_e'(cur_mode)),
        .eff_mode (eff_mode),
        .hit      (tlb_hit),
        .ppn      (tlb_ppn),
        .rd_en    (tlb_rd_en),
        .wr_en    (tlb_wr_en),
        .f_on_rd  (tlb_for),
        .f_on_wr  (tlb_fow),
        .early    (early_v),
        .pa_raw   (pa_raw)
    );

    dtc_pa_check u_pa (
        .early    (early_v),
        .pa_raw   (pa_raw),
        .final_v  (final_v),
        .pa_out   (pa_chk),
        .uncached (uc_chk)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_valid    <= 1'b0;
            rsp_pa       <= '0;
            rsp_uncached <= 1'b0;
            verdict_q    <= '{code: FLT_NONE, stat: '0};
        end else if (req_valid) begin
            rsp_valid    <= 1'b1;
            rsp_pa       <= pa_chk;
            rsp_uncached <= uc_chk;
            verdict_q    <= final_v;
        end else begin
            rsp_valid    <= 1'b0;
            rsp_pa       <= '0;
            rsp_uncached <= 1'b0;
            verdict_q    <= '{code: FLT_NONE, stat: '0};
        end
    end

    assign rsp_fault = verdict_q.code;
    assign rsp_stat  = verdict_q.stat;

    // R1
    align_stat_chk: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && rsp_fault == FLT_ALIGN) |-> ((rsp_stat & ~(ST_W'(1) << ST_WR)) == '0));

    // R12
    fault_pa_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && rsp_fault != FLT_NONE) |-> (rsp_pa == '0 && !rsp_uncached));

    // R11
    uc_clear_chk: assert property (@(posedge clk) disable iff (rst)
        rsp_uncached |-> (rsp_pa[UC_BIT] && rsp_pa[UC_CLR_HI:UC_CLR_LO] == '0));

    // R10
    impl_width_chk: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && rsp_fault == FLT_NONE) |-> ((rsp_pa & ~IMPL_MASK) == '0));

    // R6
    miss_stat_chk: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && (rsp_fault == FLT_MISS_NAT || rsp_fault == FLT_MISS_PTE))
            |-> rsp_stat[ST_MISS]);

    // R13
    valid_follow_chk: assert property (@(posedge clk) disable iff (rst)
        req_valid |=> rsp_valid);

    // R13
    idle_zero_chk: assert property (@(posedge clk) disable iff (rst)
        !req_valid |=> (!rsp_valid && rsp_pa == '0 && rsp_fault == FLT_NONE));

endmodule

// File: tb/test_dtc_translate_chk.sv
`timescale 1ns/1ps
module test_dtc_translate_chk;

    localparam int PPN_W = 32;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic [63:0] req_va = '0;
    logic [3:0]  req_size = 4'd1;
    logic        req_write = 1'b0, req_phys = 1'b0, req_alt = 1'b0, req_ptefetch = 1'b0;
    logic        pc_lsb = 1'b0;
    logic [1:0]  cur_mode = 2'd0, alt_mode = 2'd0;
    logic        tlb_hit = 1'b0;
    logic [PPN_W-1:0] tlb_ppn = '0;
    logic [3:0]  tlb_rd_en = '0, tlb_wr_en = '0;
    logic        tlb_for = 1'b0, tlb_fow = 1'b0;
    logic        rsp_valid, rsp_uncached;
    logic [63:0] rsp_pa;
    logic [2:0]  rsp_fault;
    logic [5:0]  rsp_stat;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    dtc_translate_chk #(.PPN_W(PPN_W), .PAGE_SHIFT(13)) i_dtc_translate_chk (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_va(req_va), .req_size(req_size),
        .req_write(req_write), .req_phys(req_phys), .req_alt(req_alt),
        .req_ptefetch(req_ptefetch), .pc_lsb(pc_lsb), .cur_mode(cur_mode),
        .alt_mode(alt_mode), .tlb_hit(tlb_hit), .tlb_ppn(tlb_ppn), .tlb_rd_en(tlb_rd_en),
        .tlb_wr_en(tlb_wr_en), .tlb_for(tlb_for), .tlb_fow(tlb_fow),
        .rsp_valid(rsp_valid), .rsp_pa(rsp_pa), .rsp_uncached(rsp_uncached),
        .rsp_fault(rsp_fault), .rsp_stat(rsp_stat)
    );

    typedef struct {
        logic       v;
        logic [2:0] f;
        logic [5:0] s;
        logic [63:0] pa;
        logic       uc;
    } exp_t;

    // expected result from the requirement text
    function automatic exp_t model();
        exp_t e;
        logic [63:0] pa;
        logic [1:0]  em;
        logic [5:0]  w;
        logic [3:0]  mb;
        e = '{1'b1, 3'd0, 6'd0, 64'd0, 1'b0};
        pa = '0;
        w  = req_write ? 6'h01 : 6'h00;
        em = pc_lsb ? (req_alt ? alt_mode : 2'd0) : cur_mode;
        mb = 4'b0001 << em;
        if ((req_va[3:0] & (req_size - 4'd1)) != 0) begin
            e.f = 3'd1; e.s = w; return e;
        end
        if (req_phys) pa = req_va;
        else if (!(req_va[63:42] == '0 || req_va[63:42] == '1)) begin
            e.f = 3'd2; e.s = w | 6'h12; return e;
        end else if (req_va[47:41] == 7'h7e) begin
            if (cur_mode != 2'd0) begin e.f = 3'd3; e.s = w | 6'h02; return e; end
            pa = req_va[40] ? {20'h0, 4'hf, req_va[39:0]} : {24'h0, req_va[39:0]};
        end else if (!tlb_hit) begin
            e.f = req_ptefetch ? 3'd5 : 3'd4; e.s = w | 6'h20; return e;
        end else begin
            pa = {19'h0, tlb_ppn, 13'h0} + {51'h0, req_va[12:0]};
            if (req_write) begin
                if ((tlb_wr_en & mb) == 0) begin
                    e.f = 3'd2; e.s = 6'h03 | (tlb_fow ? 6'h08 : 6'h00); return e;
                end
                if (tlb_fow) begin e.f = 3'd2; e.s = 6'h09; return e; end
            end else begin
                if ((tlb_rd_en & mb) == 0) begin
                    e.f = 3'd3; e.s = 6'h02 | (tlb_for ? 6'h04 : 6'h00); return e;
                end
                if (tlb_for) begin e.f = 3'd2; e.s = 6'h04; return e; end
            end
        end
        if (pa[63:44] != 0) begin e.f = 3'd6; return e; end
        if (pa[43]) begin
            if (&pa[43:20]) begin e.f = 3'd7; return e; end
            e.uc = 1'b1; pa[42:35] = '0;
        end
        e.pa = pa;
        return e;
    endfunction

    function automatic string tag_of(exp_t e);
        case (e.f)
            3'd0: return e.uc ? "R11" : (req_phys ? "R3" : "R7");
            3'd1: return "R1";
            3'd2: return e.s[4] ? "R4" : (e.s[0] ? "R8" : "R9");
            3'd3: return (req_va[47:41] == 7'h7e && !req_phys) ? "R5" : "R9";
            3'd4, 3'd5: return "R6";
            3'd6: return "R10";
            default: return "R11";
        endcase
    endfunction

    task automatic compare(exp_t e, string tag);
        checks++;
        if (rsp_valid !== e.v || rsp_fault !== e.f || rsp_stat !== e.s ||
            rsp_pa !== e.pa || rsp_uncached !== e.uc) begin
            errors++;
            $display("FAIL %s: got v=%0b f=%0d s=%02h pa=%016h uc=%0b exp v=%0b f=%0d s=%02h pa=%016h uc=%0b",
                     tag, rsp_valid, rsp_fault, rsp_stat, rsp_pa, rsp_uncached,
                     e.v, e.f, e.s, e.pa, e.uc);
        end
    endtask

    // drive at a falling edge, output registered at the next rise, sample at the next fall
    task automatic run(string tag);
        exp_t e;
        req_valid = 1'b1;
        e = model();
        @(negedge clk);
        compare(e, (tag == "") ? tag_of(e) : tag);
    endtask

    task automatic clear_req();
        req_va = '0; req_size = 4'd8; req_write = 0; req_phys = 0; req_alt = 0;
        req_ptefetch = 0; pc_lsb = 0; cur_mode = 0; alt_mode = 0; tlb_hit = 0;
        tlb_ppn = '0; tlb_rd_en = 4'hf; tlb_wr_en = 4'hf; tlb_for = 0; tlb_fow = 0;
    endtask

    initial begin
        #(8ns * 200000);
        errors++;
        $display("FAIL watchdog: got timeout exp completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        exp_t z;
        void'($urandom(32'd20240611));
        z = '{1'b0, 3'd0, 6'd0, 64'd0, 1'b0};
        clear_req();
        repeat (3) @(negedge clk);
        compare(z, "R13");  // reset state
        rst = 1'b0;

        // R1: misaligned write wins over bypass
        clear_req(); req_phys = 1; req_write = 1; req_size = 4'd4; req_va = 64'h1002; run("R1");
        // R3: bypass passes the address through, TLB miss ignored
        clear_req(); req_phys = 1; req_va = 64'h0000_0012_3456_7800; run("R3");
        // R10: bypass above implemented width
        clear_req(); req_phys = 1; req_va = 64'h0004_0000_0000_0000; run("R10");
        // R4: non-canonical VA, read then write
        clear_req(); req_va = 64'h0000_8000_0000_0000; run("R4");
        req_write = 1; run("R4");
        // R5: superpage, bit 40 clear
        clear_req(); req_va = 64'hffff_fc00_1234_5000; run("R5");
        // R5: superpage, bit 40 set: sign extension then uncached (R11)
        clear_req(); req_va = 64'hffff_fd7f_ffff_f000; run("R5");
        // R5: superpage in user mode, privileged override does not help
        clear_req(); req_va = 64'hffff_fc00_0000_1000; cur_mode = 2'd3; pc_lsb = 1; run("R5");
        // R11: superpage lands in internal-register space
        clear_req(); req_va = 64'hffff_fdff_fff0_0000; run("R11");
        // R6: native and table-fetch miss
        clear_req(); req_va = 64'h0000_0000_0040_0000; run("R6");
        req_ptefetch = 1; req_write = 1; run("R6");
        // R7: hit read
        clear_req(); tlb_hit = 1; tlb_ppn = 32'h0000_1234; req_va = 64'h0000_0000_0000_1ff8; run("R7");
        // R8: write without enable with fow, then enabled with fow
        clear_req(); tlb_hit = 1; req_write = 1; tlb_wr_en = 4'h0; tlb_fow = 1; run("R8");
        tlb_wr_en = 4'hf; run("R8");
        // R9: read without enable with for, then enabled with for
        clear_req(); tlb_hit = 1; tlb_rd_en = 4'h0; tlb_for = 1; run("R9");
        tlb_rd_en = 4'hf; run("R9");
        // R2: override to kernel, override to alternate, no override
        clear_req(); tlb_hit = 1; tlb_rd_en = 4'b0001; cur_mode = 2'd3; pc_lsb = 1; run("R2");
        req_alt = 1; alt_mode = 2'd3; run("R2");
        req_alt = 0; pc_lsb = 0; run("R2");
        // R10: hit with page number beyond implemented width
        clear_req(); tlb_hit = 1; tlb_ppn = 32'h8000_0000; run("R10");
        // R11: hit in internal-register space and uncached hit
        clear_req(); tlb_hit = 1; tlb_ppn = 32'h7fff_ff80; run("R11");
        tlb_ppn = 32'h4123_4567; run("R11");
        // R13: idle cycle after a request
        clear_req(); req_valid = 1'b0;
        @(negedge clk); compare(z, "R13");

        for (int i = 0; i < 4000; i++) begin
            int cat;
            clear_req();
            cat = $urandom % 6;
            case (cat)
                0: req_va = {$urandom, $urandom};
                1: req_va = {22'h0, 10'($urandom), $urandom};
                2: req_va = {22'h3fffff, 10'($urandom), $urandom};
                3: req_va = {16'hffff, 7'h7e, 9'($urandom), $urandom};
                4: req_va = {16'hffff, 7'h7e, 1'b1, 21'h1fffff, 20'($urandom)};
                default: req_va = {$urandom, $urandom} ^ 64'h0000_0400_0000_0000;
            endcase
            req_size = 4'd1 << ($urandom % 4);
            if ($urandom % 10 < 7) req_va[3:0] = req_va[3:0] & ~(req_size - 4'd1);
            req_write = 1'($urandom); req_phys = ($urandom % 8) == 0;
            req_alt = 1'($urandom); req_ptefetch = 1'($urandom); pc_lsb = 1'($urandom);
            cur_mode = 2'($urandom); alt_mode = 2'($urandom);
            tlb_hit = ($urandom % 4) != 0;
            tlb_ppn = $urandom; if ($urandom % 2) tlb_ppn[31] = 1'b0;
            tlb_rd_en = 4'($urandom); tlb_wr_en = 4'($urandom);
            tlb_for = ($urandom % 4) == 0; tlb_fow = ($urandom % 4) == 0;
            if ($urandom % 16 == 0) begin
                req_valid = 1'b0;
                @(negedge clk); compare(z, "R13");
            end else begin
                run("");
            end
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule